// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block sits between the register file of an SD host and the logic that drives the card. Software first writes a 32-bit argument and then a 32-bit command word. If the start flag of that word is set, the sequencer sends one request to the card-side interface. The request carries the command index and the argument. The sequencer then stays busy until the card side answers with a response, a length code and an error flag.

A response that matches the expected shape is placed into four 32-bit response words. A long response is stored with its words in reverse order. The block raises a command-complete pulse when the command succeeds. It raises a no-response pulse when the card side reports an error or returns a length that does not match the command. A command flagged as a clock change finishes without a bus request.

A transfer counter is loaded by software. It is reduced by data-port accesses, which count four bytes each, and by bulk moves of any size. The counter stops at zero, and reaching zero raises data-complete. If the active command asks for an automatic stop, the sequencer issues stop index 12 with argument 0 once the counter is zero. This happens either right after the command itself finishes or when a later access drains the counter. The software-visible command and argument words do not change during this, and an auto-command-done pulse marks the end of the stop.

Top module: `sd_cmd_seq`

## Requirements
- R1: Writing the command word (select code 1) with bit 31 set starts a command while the block is idle. The stored command reads back with bit 31 clear, and `busy` stays high until the response has been handled.
- R2: A request presents index bits 5:0 of the command and the stored argument. `req_valid` stays high and the index stays stable until the cycle in which `req_ready` is seen high.
- R3: With command bit 21 set, no request is sent. `evt_cmd_done` pulses in the second cycle after the starting write, and `busy` then falls.
- R4: Bit 6 asks for a response and bit 7 selects the long form. A response with bit 6 set, bit 7 clear and length code 1 (4 bytes) stores card bytes 0..3, in big-endian order, into word 0 (`resp_words[31:0]`). Words 1 to 3 are cleared.
- R5: A response with bits 6 and 7 set and length code 2 (16 bytes) stores bytes 12..15 in word 0, 8..11 in word 1, 4..7 in word 2 and 0..3 in word 3. Card byte k arrives on `rsp_data[127-8k -: 8]`.
- R6: The error flag, or a length code that does not fit bits 6 and 7, gives a one-cycle `evt_no_resp` with no `evt_cmd_done`, and the response words keep their values. Without bit 6 set, any error-free answer completes the command and leaves the words untouched.
- R7: Writing the byte count (select code 2) loads the transfer counter. Each move lowers it by its size and stops at zero. Any move whose result is zero pulses `evt_data_done` with the new count.
- R8: A data-port access counts four bytes against the counter. This is either a register write with select code 3 or a `dport_rd` pulse.
- R9: Command bit 12 may be set when a command finishes while the counter is zero. In that case the stop request (index 12, argument 0) follows at once. Its response is judged with the user command's bits 6 and 7, and its completion pulses `evt_auto_done` together with the completion event. The command and argument words read back unchanged throughout.
- R10: With command bit 12 set and the block idle, a counter access that reaches zero starts the stop request in the cycle after `evt_data_done`.
- R11: Writes to the command or argument word while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 argument, 1 command, 2 byte count, 3 data port |
| reg_wdata | input | 32 | Write data |
| dport_rd | input | 1 | Data-port read access (counts 4 bytes) |
| move_valid | input | 1 | Bulk move completed this cycle |
| move_bytes | input | CNT_W | Size of the bulk move |
| req_valid | output | 1 | Request to card side |
| req_ready | input | 1 | Card side accepts request |
| req_index | output | 6 | Command index of the request |
| req_arg | output | 32 | Argument of the request |
| rsp_valid | input | 1 | Card side answer present |
| rsp_len | input | 2 | 0 none, 1 four bytes, 2 sixteen bytes |
| rsp_err | input | 1 | Card side reports failure |
| rsp_data | input | 128 | Response bytes, byte 0 in the top bits |
| cmd_word | output | 32 | Stored command word |
| arg_word | output | 32 | Stored argument word |
| resp_words | output | 128 | Response word i at bits 32i+31:32i |
| xfer_cnt | output | CNT_W | Transfer counter |
| busy | output | 1 | Command or stop in progress |
| evt_cmd_done | output | 1 | Command-complete pulse |
| evt_no_resp | output | 1 | No-response pulse |
| evt_data_done | output | 1 | Counter reached zero pulse |
| evt_auto_done | output | 1 | Automatic stop finished pulse |

## Verification
The checks assume that the card side follows the handshake. It answers at most once per accepted request, and it drives `rsp_valid` only while a request is outstanding. Under that assumption, a request never drops before acceptance, the completion and no-response pulses never come together, and stop completion always comes with one of them. The counter never rises on a move cycle, and data-complete only appears with a zero count. The bench acts as a well-behaved card. It drops `req_ready` and `rsp_valid` after one cycle and sends exactly one answer per request after a random delay, so the stimulus stays inside these assumptions.

// File: rtl/sd_seq_pkg.sv
// Shared encodings for the SD command issue sequencer.
// Bit positions are fixed because software builds command words with them.
package sd_seq_pkg;
    localparam int BIT_START    = 31;
    localparam int BIT_CLKCHG   = 21;
    localparam int BIT_AUTOSTOP = 12;
    localparam int BIT_LONG     = 7;
    localparam int BIT_WANT     = 6;

    typedef enum logic [1:0] {
        SEL_ARG   = 2'd0,
        SEL_CMD   = 2'd1,
        SEL_BCNT  = 2'd2,
        SEL_DPORT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RLEN_NONE  = 2'd0,
        RLEN_SHORT = 2'd1,
        RLEN_LONG  = 2'd2,
        RLEN_BAD   = 2'd3
    } rsp_len_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_NOBUS
    } seq_state_e;
endpackage

// File: rtl/sd_xfer_cnt.sv
// Transfer byte counter.
// Loaded by software and reduced by data-port and bulk moves, stopping at zero.
// Assumes a load and a move in the same cycle resolve in favour of the load.
module sd_xfer_cnt #(
    parameter int CNT_W   = 16,
    parameter int PORT_SZ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dport,
    input  logic             move_valid,
    input  logic [CNT_W-1:0] move_bytes,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             data_done
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] dec;
    logic [CNT_W-1:0] nxt;
    logic             step;

    // Sum of bytes moved this cycle and the saturated remainder.
    always_comb begin
        dec  = (dport ? SUM_W'(PORT_SZ) : '0) + (move_valid ? {1'b0, move_bytes} : '0);
        step = dport || move_valid;
        nxt  = ({1'b0, cnt} > dec) ? (cnt - dec[CNT_W-1:0]) : '0;
    end

    assign cnt_zero = (cnt == '0);

    // Counter register and the zero-reached pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            data_done <= 1'b0;
        end else if (load) begin
            cnt       <= load_val;
            data_done <= 1'b0;
        end else begin
            data_done <= step && (nxt == '0);
            if (step) cnt <= nxt;
        end
    end

    AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (dport || move_valid)) |=> (cnt <= $past(cnt))); // R7
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> (cnt == '0)); // R7
endmodule

// File: rtl/sd_resp_place.sv
// Response word placement.
// Short answers go big-endian into word 0. Long answers put the last four
// card bytes in word 0 and so on, which reverses the word order.
// Assumes card byte k sits at bits 127-8k down.
module sd_resp_place #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic [WORD_W*WORDS-1:0] rsp_data,
    input  logic                    long_sel,
    output logic [WORD_W*WORDS-1:0] words
);
    localparam int TOP = WORD_W * WORDS;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        if (i == 0) begin : g_first
            // Word 0 takes the leading bytes for a short answer.
            assign words[WORD_W-1:0] = long_sel ? rsp_data[WORD_W-1:0]
                                                : rsp_data[TOP-1 -: WORD_W];
        end else begin : g_rest
            // Other words hold data only for a long answer.
            assign words[i*WORD_W +: WORD_W] = long_sel ? rsp_data[i*WORD_W +: WORD_W] : '0;
        end
    end
endmodule

// File: rtl/sd_cmd_fsm.sv
// Command sequencing state machine.
// Sends a request, waits for the card-side answer, decides complete or
// no-response, and chains the automatic stop when the counter is empty.
// Assumes the card side answers once per accepted request.
module sd_cmd_fsm
    import sd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_go,
    input  logic       load_clkchg,
    input  logic       cmd_touch,
    input  logic       clkchg_q,
    input  logic       autostop_q,
    input  logic       want_q,
    input  logic       long_q,
    input  logic       cnt_zero,
    input  logic       data_done,
    input  logic       req_ready,
    input  logic       rsp_valid,
    input  logic [1:0] rsp_len,
    input  logic       rsp_err,
    output logic       req_valid,
    output logic       auto_active,
    output logic       busy,
    output logic       resp_we,
    output logic       evt_cmd_done,
    output logic       evt_no_resp,
    output logic       evt_auto_done
);
    seq_state_e state;
    logic       is_auto;
    logic       pend;
    logic       pend_now;
    logic       rsp_ok;
    logic       finishing;
    logic       chain_auto;
    logic       idle_auto;

    // Answer judgement, finish detection and stop start conditions.
    always_comb begin
        rsp_ok     = !rsp_err && (!want_q ||
                     (long_q ? (rsp_len == RLEN_LONG) : (rsp_len == RLEN_SHORT)));
        pend_now   = pend || (data_done && autostop_q);
        finishing  = ((state == ST_WAIT) && rsp_valid) || (state == ST_NOBUS);
        chain_auto = finishing && !is_auto && autostop_q && cnt_zero;
        idle_auto  = (state == ST_IDLE) && !load_go && !cmd_touch && pend_now;
        resp_we    = (state == ST_WAIT) && rsp_valid && rsp_ok && want_q;
    end

    assign req_valid   = (state == ST_SEND);
    assign busy        = (state != ST_IDLE);
    assign auto_active = is_auto;

    // State, stop bookkeeping and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            is_auto       <= 1'b0;
            pend          <= 1'b0;
            evt_cmd_done  <= 1'b0;
            evt_no_resp   <= 1'b0;
            evt_auto_done <= 1'b0;
        end else begin
            evt_cmd_done  <= 1'b0;
            evt_no_resp   <= 1'b0;
            evt_auto_done <= 1'b0;
            pend          <= pend_now;
            case (state)
                ST_IDLE: begin
                    if (load_go) begin
                        state   <= load_clkchg ? ST_NOBUS : ST_SEND;
                        is_auto <= 1'b0;
                    end else if (idle_auto) begin
                        state   <= clkchg_q ? ST_NOBUS : ST_SEND;
                        is_auto <= 1'b1;
                        pend    <= 1'b0;
                    end
                end
                ST_SEND: if (req_ready) state <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    evt_cmd_done <= rsp_ok;
                    evt_no_resp  <= !rsp_ok;
                end
                ST_NOBUS: evt_cmd_done <= 1'b1;
                default: state <= ST_IDLE;
            endcase
            if (finishing) begin
                evt_auto_done <= is_auto;
                if (chain_auto) begin
                    state   <= clkchg_q ? ST_NOBUS : ST_SEND;
                    is_auto <= 1'b1;
                    pend    <= 1'b0;
                end else begin
                    state   <= ST_IDLE;
                    is_auto <= 1'b0;
                end
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid); // R2
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_cmd_done && evt_no_resp)); // R6
    AST_AUTO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_auto_done |-> (evt_cmd_done || evt_no_resp)); // R9
endmodule

// File: rtl/sd_cmd_seq.sv
// SD command issue sequencer top.
// Holds the command, argument and response words, and wires the state
// machine, the placement logic and the transfer counter together.
// Assumes single-cycle register write strobes from the host register file.
module sd_cmd_seq
    import sd_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int WORD_W   = 32,
    parameter int RWORDS   = 4,
    parameter int IDX_W    = 6,
    parameter int STOP_IDX = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_sel,
    input  logic [WORD_W-1:0]        reg_wdata,
    input  logic                     dport_rd,
    input  logic                     move_valid,
    input  logic [CNT_W-1:0]         move_bytes,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [IDX_W-1:0]         req_index,
    output logic [WORD_W-1:0]        req_arg,
    input  logic                     rsp_valid,
    input  logic [1:0]               rsp_len,
    input  logic                     rsp_err,
    input  logic [WORD_W*RWORDS-1:0] rsp_data,
    output logic [WORD_W-1:0]        cmd_word,
    output logic [WORD_W-1:0]        arg_word,
    output logic [WORD_W*RWORDS-1:0] resp_words,
    output logic [CNT_W-1:0]         xfer_cnt,
    output logic                     busy,
    output logic                     evt_cmd_done,
    output logic                     evt_no_resp,
    output logic                     evt_data_done,
    output logic                     evt_auto_done
);
    localparam int RESP_W = WORD_W * RWORDS;

    logic              cmd_touch;
    logic              cmd_wr;
    logic              arg_wr;
    logic              load_go;
    logic              dport;
    logic              resp_we;
    logic              auto_active;
    logic              cnt_zero;
    logic [RESP_W-1:0] placed;

    // Register access decode, gated while a command is in flight.
    always_comb begin
        cmd_touch = reg_wr && (reg_sel == SEL_CMD);
        cmd_wr    = cmd_touch && !busy;
        arg_wr    = reg_wr && (reg_sel == SEL_ARG) && !busy;
        load_go   = cmd_wr && reg_wdata[BIT_START];
        dport     = (reg_wr && (reg_sel == SEL_DPORT)) || dport_rd;
    end

    // Command and argument storage; the start flag is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= '0;
            arg_word <= '0;
        end else begin
            if (cmd_wr) begin
                cmd_word            <= reg_wdata;
                cmd_word[BIT_START] <= 1'b0;
            end
            if (arg_wr) arg_word <= reg_wdata;
        end
    end

    // Response word storage, written only on an accepted answer.
    always_ff @(posedge clk) begin
        if (!rst_n)       resp_words <= '0;
        else if (resp_we) resp_words <= placed;
    end

    // Request fields: the automatic stop overrides index and argument.
    assign req_index = auto_active ? IDX_W'(STOP_IDX) : cmd_word[IDX_W-1:0];
    assign req_arg   = auto_active ? '0 : arg_word;

    sd_resp_place #(.WORD_W(WORD_W), .WORDS(RWORDS)) u_place (
        .rsp_data (rsp_data),
        .long_sel (cmd_word[BIT_LONG]),
        .words    (placed)
    );

    sd_xfer_cnt #(.CNT_W(CNT_W), .PORT_SZ(4)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reg_wr && (reg_sel == SEL_BCNT)),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .dport      (dport),
        .move_valid (move_valid),
        .move_bytes (move_bytes),
        .cnt        (xfer_cnt),
        .cnt_zero   (cnt_zero),
        .data_done  (evt_data_done)
    );

    sd_cmd_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_go       (load_go),
        .load_clkchg   (reg_wdata[BIT_CLKCHG]),
        .cmd_touch     (cmd_touch),
        .clkchg_q      (cmd_word[BIT_CLKCHG]),
        .autostop_q    (cmd_word[BIT_AUTOSTOP]),
        .want_q        (cmd_word[BIT_WANT]),
        .long_q        (cmd_word[BIT_LONG]),
        .cnt_zero      (cnt_zero),
        .data_done     (evt_data_done),
        .req_ready     (req_ready),
        .rsp_valid     (rsp_valid),
        .rsp_len       (rsp_len),
        .rsp_err       (rsp_err),
        .req_valid     (req_valid),
        .auto_active   (auto_active),
        .busy          (busy),
        .resp_we       (resp_we),
        .evt_cmd_done  (evt_cmd_done),
        .evt_no_resp   (evt_no_resp),
        .evt_auto_done (evt_auto_done)
    );

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cmd_word) && $stable(arg_word))); // R11
endmodule

// File: tb/tb_sd_cmd_seq.sv
`timescale 1ns/1ps
module tb_sd_cmd_seq;
    localparam int CNT_W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_sel = '0;
    logic [31:0]  reg_wdata = '0;
    logic         dport_rd = 1'b0;
    logic         move_valid = 1'b0;
    logic [CNT_W-1:0] move_bytes = '0;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid = 1'b0;
    logic [1:0]   rsp_len = '0;
    logic         rsp_err = 1'b0;
    logic [127:0] rsp_data = '0;
    logic [31:0]  cmd_word, arg_word;
    logic [127:0] resp_words;
    logic [CNT_W-1:0] xfer_cnt;
    logic         busy, evt_cmd_done, evt_no_resp, evt_data_done, evt_auto_done;

    int n_chk = 0;
    int n_fail = 0;
    logic [127:0] exp_resp = '0;

    always #2.5 clk = ~clk;

    sd_cmd_seq #(.CNT_W(CNT_W)) dut (.*);

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick;
        reg_wr = 1'b0;
    endtask

    function automatic bit exp_ok(input logic [31:0] c, input logic [1:0] len, input bit err);
        if (err) return 1'b0;
        if (!c[6]) return 1'b1;
        return c[7] ? (len == 2'd2) : (len == 2'd1);
    endfunction

    function automatic logic [127:0] place(input logic [31:0] c, input logic [127:0] d,
                                           input logic [127:0] old);
        if (!c[6]) return old;
        if (c[7]) return d;
        return {96'b0, d[127:96]};
    endfunction

    // Check a visible request, then accept it after rd cycles.
    task automatic serve_req(input string tag, input logic [5:0] idx, input logic [31:0] arg, input int rd);
        chk({tag, " req_valid"}, req_valid, 1);
        chk({tag, " req_index"}, req_index, idx);
        chk({tag, " req_arg"}, req_arg, arg);
        for (int k = 0; k < rd; k++) begin
            tick;
            chk("R2 req held", {req_valid, req_index}, {1'b1, idx});
        end
        req_ready = 1'b1;
        tick;
        req_ready = 1'b0;
    endtask

    // Return an answer after sd cycles and check the outcome.
    task automatic serve_rsp(input string tag, input logic [31:0] ucmd, input logic [1:0] len,
                             input bit err, input logic [127:0] d, input int sd,
                             input bit exp_busy, input bit this_auto);
        bit ok;
        repeat (sd) tick;
        rsp_valid = 1'b1; rsp_len = len; rsp_err = err; rsp_data = d;
        tick;
        rsp_valid = 1'b0;
        ok = exp_ok(ucmd, len, err);
        if (ok) exp_resp = place(ucmd, d, exp_resp);
        chk({tag, " R6 cmd_done"}, evt_cmd_done, ok);
        chk({tag, " R6 no_resp"}, evt_no_resp, !ok);
        chk({tag, " resp_words"}, resp_words, exp_resp);
        chk({tag, " R9 auto_done"}, evt_auto_done, this_auto);
        chk({tag, " busy after"}, busy, exp_busy);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] c, a;
        logic [1:0]  len;
        bit          err;
        logic [127:0] d;
        void'($urandom(32'd4242));
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // Reset state
        chk("R1 reset cmd", cmd_word, 0);
        chk("R1 reset arg", arg_word, 0);
        chk("R4 reset resp", resp_words, 0);
        chk("R7 reset cnt", xfer_cnt, 0);
        chk("R1 reset busy", {busy, req_valid}, 0);

        // Random commands: R1 R2 R4 R5 R6
        for (int i = 0; i < 60; i++) begin
            c = {24'b0, $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1, 6'($urandom)};
            a = $urandom;
            err = ($urandom_range(9, 0) == 0);
            if ($urandom_range(3, 0) == 0) len = 2'($urandom);
            else len = c[6] ? (c[7] ? 2'd2 : 2'd1) : 2'($urandom_range(2, 0));
            d = {$urandom, $urandom, $urandom, $urandom};
            reg_write(2'd0, a);
            reg_write(2'd1, c | 32'h8000_0000);
            chk("R1 start bit clear", cmd_word, c);
            chk("R1 busy", busy, 1);
            serve_req("R2", c[5:0], a, $urandom_range(3, 0));
            serve_rsp(c[7] ? "R5" : "R4", c, len, err, d, $urandom_range(3, 0), 0, 0);
        end

        // Directed length mismatch on a long command: R6
        c = 32'h0000_00C9;
        reg_write(2'd1, c | 32'h8000_0000);
        serve_req("R6", 6'h09, a, 0);
        serve_rsp("R6 mismatch", c, 2'd1, 0, {4{32'hA5A5_5A5A}}, 1, 0, 0);

        // Clock change: R3
        reg_write(2'd1, 32'h8020_0005);
        chk("R3 no req first", {busy, req_valid}, 2'b10);
        tick;
        chk("R3 cmd_done", evt_cmd_done, 1);
        chk("R3 no req second", {busy, req_valid}, 2'b00);
        chk("R3 cmd word", cmd_word, 32'h0020_0005);

        // Writes while busy are dropped: R11
        reg_write(2'd0, 32'h1111_2222);
        c = 32'h0000_0051;
        reg_write(2'd1, c | 32'h8000_0000);
        serve_req("R11", 6'h11, 32'h1111_2222, 0);
        reg_write(2'd0, 32'hDEAD_BEEF);
        reg_write(2'd1, 32'h8000_0005);
        chk("R11 cmd kept", cmd_word, c);
        chk("R11 arg kept", arg_word, 32'h1111_2222);
        serve_rsp("R11", c, 2'd1, 0, {32'hCAFE_F00D, 96'h0}, 0, 0, 0);

        // Counter: R7 R8
        reg_write(2'd2, 32'd10);
        chk("R7 load", xfer_cnt, 10);
        reg_write(2'd3, 32'h0403_0201);
        chk("R8 dport write", {xfer_cnt, evt_data_done}, {16'd6, 1'b0});
        move_valid = 1'b1; move_bytes = 16'd3;
        tick;
        move_valid = 1'b0;
        chk("R7 move", {xfer_cnt, evt_data_done}, {16'd3, 1'b0});
        move_valid = 1'b1; move_bytes = 16'd100;
        tick;
        move_valid = 1'b0;
        chk("R7 saturate", {xfer_cnt, evt_data_done}, {16'd0, 1'b1});
        chk("R7 no auto", busy, 0);

        // Auto stop chained after the command: R9
        reg_write(2'd0, 32'h0000_0055);
        c = 32'h0000_1052;
        reg_write(2'd1, c | 32'h8000_0000);
        serve_req("R9 user", 6'h12, 32'h55, 1);
        serve_rsp("R9 user", c, 2'd1, 0, {32'h0102_0304, 96'h0}, 0, 1, 0);
        chk("R9 cmd restored", cmd_word, c);
        chk("R9 arg restored", arg_word, 32'h55);
        serve_req("R9 stop", 6'd12, 32'h0, 1);
        serve_rsp("R9 stop", c, 2'd1, 0, {32'h0A0B_0C0D, 96'h0}, 1, 0, 1);
        chk("R9 cmd after", cmd_word, c);

        // Auto stop after the counter drains: R10
        reg_write(2'd2, 32'd8);
        c = 32'h0000_1003;
        reg_write(2'd1, c | 32'h8000_0000);
        serve_req("R10 user", 6'h03, 32'h55, 0);
        serve_rsp("R10 user", c, 2'd0, 0, '0, 0, 0, 0);
        reg_write(2'd3, 32'h0);
        chk("R10 cnt 4", xfer_cnt, 4);
        dport_rd = 1'b1;
        tick;
        dport_rd = 1'b0;
        chk("R10 data_done", {xfer_cnt, evt_data_done, req_valid}, {16'd0, 1'b1, 1'b0});
        tick;
        serve_req("R10 stop", 6'd12, 32'h0, 0);
        serve_rsp("R10 stop", c, 2'd0, 0, '0, 0, 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule